// File: doc/BRIEF.md
# Multi-Warp Instruction Issue Buffer with Register Scoreboard

This block sits between decode and execute in an in-order core that interleaves several warps. Every decoded instruction carries the number of the warp it belongs to, up to two source register numbers, an optional destination register number and an opaque tag. On acceptance it is appended to a small FIFO owned by that warp. Each warp's FIFO therefore holds that warp's instructions in program order. No warp can block another warp's queue.

In every cycle the block looks at the heads of all warp FIFOs. A head is eligible when its FIFO is not empty and none of its registers is marked busy for that warp. The lowest-numbered eligible warp sends its head to execute in that same cycle, and only that warp does. An issued instruction that writes a register marks that (warp, register) pair busy. The pair stays busy until the commit port names it again. Register numbers are private to each warp, so r5 of warp 1 and r5 of warp 2 are unrelated.

Top module: `warp_issue_sb`

## Requirements
- R1: Each warp owns a FIFO of BUF_DEPTH entries. Instructions of one warp leave in the order they were accepted. When `out_valid` is high, `out_tag`, `out_has_dst` and `out_dst` carry the fields of the issuing warp's oldest entry.
- R2: `in_ready` is high exactly when the FIFO selected by `in_warp` holds fewer than BUF_DEPTH entries. This count is taken before any issue in the same cycle. An instruction is accepted at a rising edge where `in_valid` and `in_ready` are both high.
- R3: At most one instruction issues per cycle. When several heads are eligible, the one with the smallest warp number issues and `out_warp` names it.
- R4: `out_valid` is high exactly when at least one head is eligible. A head is not eligible while its `src_a`, its `src_b`, or (if `has_dst` is 1) its `dst` is busy for its own warp. An accepted instruction can issue in the cycle after the edge that accepted it.
- R5: An issue with `out_has_dst` = 1 marks (`out_warp`, `out_dst`) busy from the next cycle on.
- R6: A commit (`cmt_valid` high) clears the busy mark of (`cmt_warp`, `cmt_dst`) from the next cycle on. A reservation of the same pair in the same cycle takes precedence over the clear.
- R7: An issue with `out_has_dst` = 0 leaves every busy mark unchanged.
- R8: While `rst_n` is low, every FIFO is emptied and every busy mark is cleared. After reset, `out_valid` is 0 and `in_ready` is 1 for every warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Target warp FIFO has room |
| in_warp | input | clog2(NUM_WARPS) | Warp of the incoming instruction |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | clog2(NUM_REGS) | Destination register |
| in_src_a | input | clog2(NUM_REGS) | First source register |
| in_src_b | input | clog2(NUM_REGS) | Second source register |
| in_tag | input | TAG_W | Opaque instruction tag |
| out_valid | output | 1 | An instruction issues this cycle |
| out_warp | output | clog2(NUM_WARPS) | Warp of the issued instruction |
| out_has_dst | output | 1 | Issued instruction writes a register |
| out_dst | output | clog2(NUM_REGS) | Destination of the issued instruction |
| out_tag | output | TAG_W | Tag of the issued instruction |
| cmt_valid | input | 1 | A register write has completed |
| cmt_warp | input | clog2(NUM_WARPS) | Warp of the completed write |
| cmt_dst | input | clog2(NUM_REGS) | Register of the completed write |

## Verification
The assertions assume three things about the inputs. A commit names only a (warp, register) pair that is currently busy. Register and warp numbers stay below NUM_REGS and NUM_WARPS. An instruction offered while `in_ready` is low is held unchanged until it is accepted. The stimulus keeps a list of outstanding writes and commits only entries from that list, each entry once. It draws numbers inside the configured ranges and holds a refused instruction until it is taken. Register numbers are drawn from a narrow set so that hazards and full FIFOs occur often.

// File: rtl/wis_pkg.sv
package wis_pkg;
   // index width helper: at least one bit, even for a single element
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/wis_fifo.sv
module wis_fifo #(
   parameter int DEPTH = 4,
   parameter int DW    = 8,
   localparam int PW   = wis_pkg::idx_w(DEPTH),
   localparam int CW   = wis_pkg::idx_w(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;

   generate
      if (DEPTH == 1) begin : g_single
         assign rd_nxt = '0;
         assign wr_nxt = '0;
      end else begin : g_ring
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   assign dout  = mem[rd_ptr];
   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
endmodule

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
   parameter int NW  = 4,
   parameter int NR  = 32,
   localparam int WW = wis_pkg::idx_w(NW),
   localparam int RW = wis_pkg::idx_w(NR),
   localparam int NB = NW * NR
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NW-1:0]         hd_has_dst,
   input  logic [NW-1:0][RW-1:0] hd_dst,
   input  logic [NW-1:0][RW-1:0] hd_sa,
   input  logic [NW-1:0][RW-1:0] hd_sb,
   output logic [NW-1:0]         hazard,
   input  logic                  set_en,
   input  logic [WW-1:0]         set_warp,
   input  logic [RW-1:0]         set_reg,
   input  logic                  clr_en,
   input  logic [WW-1:0]         clr_warp,
   input  logic [RW-1:0]         clr_reg,
   output logic [NB-1:0]         busy
);
   logic [NB-1:0] set_m, clr_m;

   // per-warp hazard test on the head entry, using that warp's own bits
   generate
      for (genvar w = 0; w < NW; w++) begin : g_haz
         logic sa_hit, sb_hit, d_hit;
         assign sa_hit = busy[w*NR + int'(hd_sa[w])];
         assign sb_hit = busy[w*NR + int'(hd_sb[w])];
         assign d_hit  = hd_has_dst[w] & busy[w*NR + int'(hd_dst[w])];
         assign hazard[w] = sa_hit | sb_hit | d_hit;
      end
   endgenerate

   always_comb begin
      set_m = '0;
      clr_m = '0;
      if (set_en) set_m[int'(set_warp)*NR + int'(set_reg)] = 1'b1;
      if (clr_en) clr_m[int'(clr_warp)*NR + int'(clr_reg)] = 1'b1;
   end

   // a reservation overrides a release of the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy <= '0;
      else        busy <= (busy & ~clr_m) | set_m;
   end
endmodule

// File: rtl/wis_first_pick.sv
module wis_first_pick #(
   parameter int N   = 4,
   localparam int IW = wis_pkg::idx_w(N)
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      any   = |req;
      grant = '0;
      grant[idx] = any;
   end
endmodule

// File: rtl/warp_issue_sb.sv
module warp_issue_sb #(
   parameter int NUM_WARPS = 4,
   parameter int BUF_DEPTH = 4,
   parameter int NUM_REGS  = 32,
   parameter int TAG_W     = 8,
   localparam int WW       = wis_pkg::idx_w(NUM_WARPS),
   localparam int RW       = wis_pkg::idx_w(NUM_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [WW-1:0] in_warp,
   input  logic          in_has_dst,
   input  logic [RW-1:0] in_dst,
   input  logic [RW-1:0] in_src_a,
   input  logic [RW-1:0] in_src_b,
   input  logic [TAG_W-1:0] in_tag,
   output logic          out_valid,
   output logic [WW-1:0] out_warp,
   output logic          out_has_dst,
   output logic [RW-1:0] out_dst,
   output logic [TAG_W-1:0] out_tag,
   input  logic          cmt_valid,
   input  logic [WW-1:0] cmt_warp,
   input  logic [RW-1:0] cmt_dst
);
   localparam int EW = 1 + 3*RW + TAG_W;
   localparam int CW = wis_pkg::idx_w(BUF_DEPTH + 1);
   localparam int NB = NUM_WARPS * NUM_REGS;

   generate
      if (NUM_WARPS < 1 || BUF_DEPTH < 1 || NUM_REGS < 2 || TAG_W < 1) begin : g_bad_cfg
         $error("warp_issue_sb: illegal parameter set");
      end
   endgenerate

   logic [EW-1:0] in_ent;
   logic [NUM_WARPS-1:0][EW-1:0] head;
   logic [NUM_WARPS-1:0] full, empty, haz, elig, grant, push;
   logic [NUM_WARPS-1:0] hd_has_dst;
   logic [NUM_WARPS-1:0][RW-1:0] hd_dst, hd_sa, hd_sb;
   logic [NUM_WARPS-1:0][TAG_W-1:0] hd_tag;
   logic [NUM_WARPS*CW-1:0] occ;
   logic [NB-1:0] sb_busy;
   logic [WW-1:0] pick_idx;
   logic pick_any;

   assign in_ent   = {in_has_dst, in_dst, in_src_a, in_src_b, in_tag};
   assign in_ready = ~full[in_warp];

   generate
      for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
         logic [CW-1:0] cnt_w;
         assign push[w] = in_valid & in_ready & (in_warp == WW'(w));

         wis_fifo #(.DEPTH(BUF_DEPTH), .DW(EW)) u_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[w]),
            .din   (in_ent),
            .pop   (grant[w]),
            .dout  (head[w]),
            .cnt   (cnt_w),
            .full  (full[w]),
            .empty (empty[w])
         );

         assign occ[w*CW +: CW] = cnt_w;
         assign hd_has_dst[w]   = head[w][EW-1];
         assign hd_dst[w]       = head[w][EW-2 -: RW];
         assign hd_sa[w]        = head[w][EW-2-RW -: RW];
         assign hd_sb[w]        = head[w][EW-2-2*RW -: RW];
         assign hd_tag[w]       = head[w][TAG_W-1:0];
      end
   endgenerate

   wis_scoreboard #(.NW(NUM_WARPS), .NR(NUM_REGS)) u_sb (
      .clk        (clk),
      .rst_n      (rst_n),
      .hd_has_dst (hd_has_dst),
      .hd_dst     (hd_dst),
      .hd_sa      (hd_sa),
      .hd_sb      (hd_sb),
      .hazard     (haz),
      .set_en     (out_valid & out_has_dst),
      .set_warp   (out_warp),
      .set_reg    (out_dst),
      .clr_en     (cmt_valid),
      .clr_warp   (cmt_warp),
      .clr_reg    (cmt_dst),
      .busy       (sb_busy)
   );

   assign elig = ~empty & ~haz;

   wis_first_pick #(.N(NUM_WARPS)) u_pick (
      .req   (elig),
      .grant (grant),
      .any   (pick_any),
      .idx   (pick_idx)
   );

   assign out_valid   = pick_any;
   assign out_warp    = pick_idx;
   assign out_has_dst = hd_has_dst[pick_idx];
   assign out_dst     = hd_dst[pick_idx];
   assign out_tag     = hd_tag[pick_idx];
endmodule

// File: rtl/wis_chk.sv
module wis_chk #(
   parameter int NW    = 4,
   parameter int DEPTH = 4,
   parameter int NR    = 32,
   localparam int WW   = wis_pkg::idx_w(NW),
   localparam int RW   = wis_pkg::idx_w(NR),
   localparam int CW   = wis_pkg::idx_w(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic [WW-1:0] in_warp,
   input logic          out_valid,
   input logic [WW-1:0] out_warp,
   input logic          out_has_dst,
   input logic [RW-1:0] out_dst,
   input logic          cmt_valid,
   input logic [WW-1:0] cmt_warp,
   input logic [RW-1:0] cmt_dst,
   input logic [NW*NR-1:0] busy,
   input logic [NW-1:0] eligible,
   input logic [NW-1:0] hazard,
   input logic [NW*CW-1:0] occ
);
   logic [NW-1:0] low_mask;
   int res_idx, rel_idx;
   assign low_mask = (NW'(1) << out_warp) - NW'(1);
   assign res_idx  = int'(out_warp) * NR + int'(out_dst);
   assign rel_idx  = int'(cmt_warp) * NR + int'(cmt_dst);

   generate
      for (genvar w = 0; w < NW; w++) begin : g_occ
         p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
            occ[w*CW +: CW] <= CW'(DEPTH));
      end
   endgenerate

   p_refuse_only_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |-> (occ[int'(in_warp)*CW +: CW] == CW'(DEPTH)));

   p_lowest_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((eligible & low_mask) == '0));

   p_no_hazard_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !hazard[out_warp]);

   p_idle_none_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (eligible == '0));

   p_reserve_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_has_dst) |=> busy[$past(res_idx)]);

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && !(out_valid && out_has_dst && res_idx == rel_idx))
      |=> !busy[$past(rel_idx)]);

   p_nodst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_has_dst && !cmt_valid) |=> (busy == $past(busy)));
endmodule

bind warp_issue_sb wis_chk #(.NW(NUM_WARPS), .DEPTH(BUF_DEPTH), .NR(NUM_REGS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .in_warp     (in_warp),
   .out_valid   (out_valid),
   .out_warp    (out_warp),
   .out_has_dst (out_has_dst),
   .out_dst     (out_dst),
   .cmt_valid   (cmt_valid),
   .cmt_warp    (cmt_warp),
   .cmt_dst     (cmt_dst),
   .busy        (sb_busy),
   .eligible    (elig),
   .hazard      (haz),
   .occ         (occ)
);

// File: tb/warp_issue_sb_tb.sv
`timescale 1ns/1ps
module warp_issue_sb_tb;
   localparam int NW = 4, DEPTH = 4, NR = 32, TW = 8, WW = 2, RW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic in_valid = 1'b0, in_ready, in_has_dst = 1'b0;
   logic [WW-1:0] in_warp = '0;
   logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
   logic [TW-1:0] in_tag = '0;
   logic out_valid, out_has_dst;
   logic [WW-1:0] out_warp;
   logic [RW-1:0] out_dst;
   logic [TW-1:0] out_tag;
   logic cmt_valid = 1'b0;
   logic [WW-1:0] cmt_warp = '0;
   logic [RW-1:0] cmt_dst = '0;

   warp_issue_sb #(.NUM_WARPS(NW), .BUF_DEPTH(DEPTH), .NUM_REGS(NR), .TAG_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_warp(in_warp),
      .in_has_dst(in_has_dst), .in_dst(in_dst), .in_src_a(in_src_a),
      .in_src_b(in_src_b), .in_tag(in_tag),
      .out_valid(out_valid), .out_warp(out_warp), .out_has_dst(out_has_dst),
      .out_dst(out_dst), .out_tag(out_tag),
      .cmt_valid(cmt_valid), .cmt_warp(cmt_warp), .cmt_dst(cmt_dst));

   typedef struct packed {
      logic          hd;
      logic [RW-1:0] dst, sa, sb;
      logic [TW-1:0] tag;
   } ent_t;

   ent_t mq[NW][$];
   bit   mbusy[NW][NR];
   int   pw[$], pr[$];
   int   vec_cnt = 0, err_cnt = 0;
   bit   done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      vec_cnt++;
      if (!ok) begin
         err_cnt++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit blocked(input int w, input ent_t e);
      return mbusy[w][e.sa] || mbusy[w][e.sb] || (e.hd && mbusy[w][e.dst]);
   endfunction

   task automatic model_clear();
      for (int w = 0; w < NW; w++) begin
         mq[w].delete();
         for (int r = 0; r < NR; r++) mbusy[w][r] = 0;
      end
      pw.delete();
      pr.delete();
   endtask

   // one clock: drive at the falling edge, compare, then advance the model
   task automatic step(input bit iv, input int iw, input bit ihd, input int idst,
                       input int isa, input int isb, input int itag,
                       input bit cv, input int cw, input int cr,
                       output bit acc, output bit iss);
      ent_t e;
      bit   exp_rdy, exp_v;
      int   exp_w;
      @(negedge clk);
      in_valid = iv; in_warp = WW'(iw); in_has_dst = ihd; in_dst = RW'(idst);
      in_src_a = RW'(isa); in_src_b = RW'(isb); in_tag = TW'(itag);
      cmt_valid = cv; cmt_warp = WW'(cw); cmt_dst = RW'(cr);
      #1;
      exp_rdy = (mq[iw].size() < DEPTH);
      exp_v = 0; exp_w = 0;
      for (int w = NW - 1; w >= 0; w--)
         if (mq[w].size() > 0 && !blocked(w, mq[w][0])) begin exp_v = 1; exp_w = w; end
      chk(in_ready == exp_rdy, "R2", "in_ready", in_ready, exp_rdy);
      chk(out_valid == exp_v, "R4", "out_valid", out_valid, exp_v);
      if (exp_v) begin
         e = mq[exp_w][0];
         chk(out_warp == WW'(exp_w), "R3", "out_warp", out_warp, exp_w);
         chk(out_tag == e.tag, "R1", "out_tag", out_tag, e.tag);
         chk(out_has_dst == e.hd && (!e.hd || out_dst == e.dst), "R1", "out_dst",
             {out_has_dst, out_dst}, {e.hd, e.dst});
      end
      acc = iv && exp_rdy;
      iss = exp_v;
      if (exp_v) void'(mq[exp_w].pop_front());
      if (acc) begin
         e.hd = ihd; e.dst = RW'(idst); e.sa = RW'(isa); e.sb = RW'(isb); e.tag = TW'(itag);
         mq[iw].push_back(e);
      end
      if (cv) mbusy[cw][cr] = 0;
      if (exp_v && out_has_dst) begin
         mbusy[exp_w][out_dst] = 1;
         pw.push_back(exp_w);
         pr.push_back(int'(out_dst));
      end
   endtask

   task automatic idle(output bit iss);
      bit a;
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, a, iss);
   endtask

   task automatic reset_check();
      @(negedge clk);
      in_valid = 0; cmt_valid = 0;
      #1;
      chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
      for (int w = 0; w < NW; w++) begin
         in_warp = WW'(w);
         #0.1;
         chk(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         err_cnt++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
         $finish;
      end
   end

   initial begin
      bit a, s;
      bit held;
      int hw, hhd, hdst, hsa, hsb, htag, tagc;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      reset_check();

      // R5 / R6: producer then dependent consumer on warp 1
      step(1, 1, 1, 5, 0, 0, 1, 0, 0, 0, a, s);
      step(1, 1, 0, 0, 5, 0, 2, 0, 0, 0, a, s);
      chk(out_valid && out_tag == 8'd1, "R5", "producer issues", out_tag, 1);
      idle(s);
      chk(out_valid == 1'b0, "R5", "consumer held by busy r5", out_valid, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1, 1, 5, a, s);
      chk(out_valid == 1'b0, "R6", "release not visible same cycle", out_valid, 0);
      idle(s);
      chk(out_valid && out_tag == 8'd2, "R6", "consumer after release", out_tag, 2);

      // R7: no-destination instruction leaves r6 free
      step(1, 2, 0, 6, 0, 0, 3, 0, 0, 0, a, s);
      step(1, 2, 0, 0, 6, 0, 4, 0, 0, 0, a, s);
      idle(s);
      chk(out_valid && out_tag == 8'd4, "R7", "reader of r6 not blocked", out_tag, 4);

      // R2: fill warp 1 behind a blocked head
      step(1, 1, 1, 7, 0, 0, 10, 0, 0, 0, a, s);
      for (int t = 11; t <= 14; t++) step(1, 1, 0, 0, 7, 0, t, 0, 0, 0, a, s);
      step(1, 1, 0, 0, 0, 0, 15, 0, 0, 0, a, s);
      chk(in_ready == 1'b0 && !a, "R2", "full warp refuses", in_ready, 0);
      step(1, 1, 0, 0, 0, 0, 15, 1, 1, 7, a, s);
      do step(1, 1, 0, 0, 0, 0, 15, 0, 0, 0, a, s); while (!a);
      repeat (8) idle(s);

      // random traffic with narrow register range
      held = 0; tagc = 20;
      for (int c = 0; c < 3000; c++) begin
         bit iv, cv;
         int cw, cr;
         if (!held) begin
            hw = $urandom % NW; hhd = (($urandom % 3) != 0); hdst = $urandom % 4;
            hsa = $urandom % 4; hsb = $urandom % 4; htag = tagc % 256; tagc++;
         end
         iv = held || (($urandom % 5) != 0);
         cv = 0; cw = 0; cr = 0;
         if (pw.size() > 0 && ($urandom % 4) == 0) begin
            int k;
            k = $urandom % pw.size();
            cv = 1; cw = pw[k]; cr = pr[k];
            pw.delete(k); pr.delete(k);
         end
         step(iv, hw, hhd[0], hdst, hsa, hsb, htag, cv, cw, cr, a, s);
         held = iv && !a;
      end

      // mid-run reset clears buffers and busy marks
      @(negedge clk);
      rst_n = 1'b0; in_valid = 0; cmt_valid = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_clear();
      reset_check();
      step(1, 0, 1, 3, 1, 2, 99, 0, 0, 0, a, s);
      idle(s);
      chk(out_valid && out_tag == 8'd99, "R8", "issue after reset, no stale busy", out_tag, 99);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   end
endmodule